// File: doc/BRIEF.md
# Fractional-N Feedback Clock Divider

This block divides a fast oscillator clock by a programmable ratio with eighth-cycle resolution. It drives the feedback input of a phase-locked loop. An 8-bit ratio word holds an integer part and a fraction in eighths. The block emits a feedback pulse train whose average period, counted in oscillator cycles, equals that ratio.

Each output period lasts either N or N+1 oscillator cycles. A 3-bit fraction accumulator makes that choice. At every period boundary it adds the fraction field. When the sum overflows, the next period is one cycle longer. Because of this dithering, 2.5 is produced as alternating periods of 2 and 3 cycles.

The ratio word is read only at a period boundary, so the ratio may change at any time. An integer field of zero counts as one.

Top module: `frac_fb_divider`

## Requirements
- R1: The ratio word `ratio_i[7:3]` is the integer part N and `ratio_i[2:0]` is the fraction in eighths. The mean output period is the word's value divided by 8, in input cycles.
- R2: Every output period, measured from one `pulse_o` high cycle to the next, lasts either N or N+1 clock cycles.
- R3: With a constant ratio word, any 8 consecutive output periods add up to exactly the effective word value, which is 8·N + fraction clock cycles.
- R4: With a fraction field of zero, every output period lasts exactly N cycles.
- R5: An integer field of 0 is treated as 1. Word 0 gives a period of 1 cycle, and word 4 gives 8 periods totalling 12 cycles.
- R6: Reset clears the accumulator. The first period after reset lasts N cycles, and for word 20 (2.5) the periods run 2, 3, 2, 3.
- R7: The ratio word is sampled only at a period boundary. A change during a period leaves that period at its old length, and the new ratio applies from the following period.
- R8: While `rst_ni` is low, `pulse_o` is 0. The first pulse appears on the first rising clock edge after reset is released.
- R9: `pulse_o` is high for one cycle per period when the period exceeds 1 cycle. At a period of 1 cycle it stays high on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock to be divided |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ratio_i | input | 8 | Division ratio, integer part in [7:3], eighths in [2:0] |
| pulse_o | output | 1 | Feedback pulse, one per output period |

## Verification
The hardest condition to reach is a ratio change that lands in the middle of a period whose length has already been fixed. The stimulus runs at a long integer ratio and waits for a pulse. Within that same low clock phase it switches to a short ratio. It then checks that the next interval still has the old length and that the intervals after it take the new one. The accumulator's starting phase is fixed only right after reset. The exact 2, 3, 2, 3 pattern is therefore measured straight from reset release, while the 8-period sums are taken from whatever accumulator phase earlier tests left behind.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
  localparam int unsigned INT_W_DEF  = 5;
  localparam int unsigned FRAC_W_DEF = 3;
endpackage

// File: rtl/frac_div_decode.sv
module frac_div_decode #(
  parameter int unsigned INT_W  = frac_div_pkg::INT_W_DEF,
  parameter int unsigned FRAC_W = frac_div_pkg::FRAC_W_DEF,
  localparam int unsigned RATIO_W = INT_W + FRAC_W
) (
  input  logic [RATIO_W-1:0] ratio_i,
  output logic [INT_W-1:0]   int_o,
  output logic [FRAC_W-1:0]  frac_o
);
  logic [INT_W-1:0] int_raw;

  assign int_raw = ratio_i[RATIO_W-1:FRAC_W];
  assign frac_o  = ratio_i[FRAC_W-1:0];

  // zero integer part clamps to divide-by-one
  always_comb begin
    int_o = int_raw;
    if (int_raw == '0) int_o = INT_W'(1);
  end
endmodule

// File: rtl/frac_div_accum.sv
module frac_div_accum #(
  parameter int unsigned FRAC_W = frac_div_pkg::FRAC_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic              carry_o
);
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   sum;

  assign sum     = {1'b0, acc_q} + {1'b0, frac_i};
  assign carry_o = sum[FRAC_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= sum[FRAC_W-1:0];
  end

  assert_carry_needs_frac_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frac_i == '0) |-> !carry_o);
endmodule

// File: rtl/frac_div_counter.sv
module frac_div_counter #(
  parameter int unsigned INT_W = frac_div_pkg::INT_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INT_W-1:0] int_i,
  input  logic             carry_i,
  output logic             boundary_o,
  output logic             pulse_o
);
  logic [INT_W-1:0] cnt_q;
  logic [INT_W-1:0] reload;

  assign boundary_o = (cnt_q == '0);
  // period length is int_i + carry_i, so reload with length - 1
  assign reload = int_i - INT_W'(1) + INT_W'(carry_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_o <= 1'b0;
    end else begin
      pulse_o <= boundary_o;
      if (boundary_o) cnt_q <= reload;
      else            cnt_q <= cnt_q - INT_W'(1);
    end
  end

  assert_count_down_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> (cnt_q == $past(cnt_q) - INT_W'(1)));

  assert_len_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_o |=> ({1'b0, cnt_q} <= {1'b0, $past(int_i)}));

  assert_pulse_at_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |-> $past(boundary_o));
endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider #(
  parameter int unsigned INT_W  = frac_div_pkg::INT_W_DEF,
  parameter int unsigned FRAC_W = frac_div_pkg::FRAC_W_DEF,
  localparam int unsigned RATIO_W = INT_W + FRAC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               pulse_o
);
  logic [INT_W-1:0]  int_eff;
  logic [FRAC_W-1:0] frac;
  logic              carry;
  logic              boundary;

  frac_div_decode #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_decode (
    .ratio_i (ratio_i),
    .int_o   (int_eff),
    .frac_o  (frac)
  );

  frac_div_accum #(.FRAC_W(FRAC_W)) u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (boundary),
    .frac_i  (frac),
    .carry_o (carry)
  );

  frac_div_counter #(.INT_W(INT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_i      (int_eff),
    .carry_i    (carry),
    .boundary_o (boundary),
    .pulse_o    (pulse_o)
  );

  assert_int_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_eff != '0);

  always_comb begin
    if (!rst_ni) assert_quiet_in_reset_R8: assert (pulse_o == 1'b0);
  end
endmodule

// File: tb/frac_fb_divider_test.sv
module frac_fb_divider_test;
  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_ni;
  logic [7:0] ratio;
  logic       pulse;

  int checks   = 0;
  int failures = 0;
  int per [0:15];

  frac_fb_divider uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .ratio_i (ratio),
    .pulse_o (pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_word(input int w);
    int n = w >> 3;
    if (n == 0) n = 1;
    return n * 8 + (w & 7);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Starting at (or waiting for) a pulse, records k pulse-to-pulse intervals
  task automatic measure(input int k);
    while (!pulse) @(negedge clk);
    for (int i = 0; i < k; i++) begin
      int c = 0;
      do begin
        @(negedge clk);
        c++;
      end while (!pulse);
      per[i] = c;
    end
  endtask

  task automatic do_reset(input logic [7:0] w);
    @(negedge clk);
    ratio  = w;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    check(pulse == 1'b0, "R8 reset low", pulse, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    check(pulse == 1'b1, "R8 first pulse", pulse, 1);
  endtask

  task automatic test_reset_pattern_R6;
    do_reset(8'd20);
    measure(4);
    check(per[0] == 2, "R6 period0", per[0], 2);
    check(per[1] == 3, "R6 period1", per[1], 3);
    check(per[2] == 2, "R6 period2", per[2], 2);
    check(per[3] == 3, "R6 period3", per[3], 3);
  endtask

  task automatic test_integer_R4(input int n);
    ratio = 8'(n << 3);
    measure(2);
    measure(6);
    for (int i = 0; i < 6; i++) check(per[i] == n, "R4 integer period", per[i], n);
  endtask

  task automatic test_frac_sum_R3(input int w);
    int sum = 0;
    int n = w >> 3;
    if (n == 0) n = 1;
    ratio = 8'(w);
    measure(1);
    measure(8);
    for (int i = 0; i < 8; i++) begin
      sum += per[i];
      check(per[i] == n || per[i] == n + 1, "R2 period in {N,N+1}", per[i], n);
    end
    check(sum == eff_word(w), "R3/R1 eight-period total", sum, eff_word(w));
  endtask

  task automatic test_zero_int_R5;
    int sum = 0;
    ratio = 8'd0;
    measure(1);
    measure(8);
    for (int i = 0; i < 8; i++) check(per[i] == 1, "R5 word0 period", per[i], 1);
    ratio = 8'd4;
    measure(1);
    measure(8);
    for (int i = 0; i < 8; i++) sum += per[i];
    check(sum == 12, "R5 word4 total", sum, 12);
  endtask

  task automatic test_width_R9;
    ratio = 8'd8;
    measure(1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(pulse == 1'b1, "R9 ratio1 always high", pulse, 1);
    end
    ratio = 8'd16;
    measure(2);
    @(negedge clk);
    check(pulse == 1'b0, "R9 single-cycle pulse", pulse, 0);
  endtask

  task automatic test_change_R7;
    ratio = 8'd80;
    measure(2);
    ratio = 8'd24;
    measure(3);
    check(per[0] == 10, "R7 running period keeps old ratio", per[0], 10);
    check(per[1] == 3, "R7 new ratio next period", per[1], 3);
    check(per[2] == 3, "R7 new ratio steady", per[2], 3);
  endtask

  initial begin
    rst_ni = 1'b0;
    ratio  = 8'd0;
    test_reset_pattern_R6();
    test_integer_R4(5);
    test_integer_R4(31);
    test_frac_sum_R3(9);
    test_frac_sum_R3(43);
    test_frac_sum_R3(255);
    test_frac_sum_R3(13);
    test_frac_sum_R3(20);
    test_zero_int_R5();
    test_width_R9();
    test_change_R7();
    do_reset(8'd27);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule